// File: doc/BRIEF.md
# Resonator Amplitude Control Loop

This block holds the vibration amplitude of a resonator at a programmed target. On every strobe of an amplitude estimate taken from the tracking engine as an I/Q magnitude, it forms the error between the target and the estimate. A proportional-integral law turns that error into a drive demand. The demand is clamped to a programmable window and applied to a drive-level word through a slope limiter, so the word never jumps. The word feeds a DAC or PWM stage outside this block.

Alongside the loop, the block keeps a set of telemetry values that show whether an amplitude reading can be trusted. These are the raw control demand, the share of updates spent against a clamp, the number of clipped samples, the time from start to the first settled state, an RMS figure for the loop error, and how many times the loop lost the settled state and regained it. A start pulse begins regulation from zero drive. A later start pulse restarts it and clears all telemetry.

Top module: `amp_loop_ctrl`

## Requirements
- R1: After reset and until the first `start`, `drive_level`, `effort`, every counter, `sat_pct`, `lock_time`, `err_rms` and `locked` are 0, and `amp_valid` strobes are ignored: they change no output.
- R2: An update is a clock edge with `amp_valid` high, the loop started and `start` low. The error is e = `setpoint` − `amp_est` (signed). With FRAC fractional gain bits, the demand is floor((kp·e + I_new)/2^FRAC), where I_new = I + ki·e. After each update, `effort` shows this demand, saturated to its signed width.
- R3: The drive target is the demand clamped to [`drive_min`, `drive_max`]. `drive_level` never rises above `drive_max`.
- R4: On each update, `drive_level` moves toward the target by at most `ramp_step`. A `start` edge sets the drive and the integrator I to 0, so startup climbs at a bounded slope.
- R5: Anti-windup. When the demand falls outside the clamp window, I keeps its old value. Otherwise I takes I_new.
- R6: `clip_count` rises by one on each update whose `adc_clip` is high, and saturates at its maximum.
- R7: The block counts updates in windows of SAT_WIN. At the last update of each window, `sat_pct` becomes floor(n·100/SAT_WIN), where n is the number of saturated updates in that window. Between window ends it holds its value.
- R8: The loop becomes `locked` after SETTLE_N consecutive updates with |e| < `settle_band`. An update with |e| ≥ `settle_band` clears `locked` and the run count. On the first lock after a start, `lock_time` is set to the number of clock edges from the start edge to the lock edge.
- R9: `reacq_count` rises by one each time the loop settles again after having lost lock since the last start.
- R10: `err_rms` is the integer square root of an exponential average of e². The average is M ← M + floor((e² − M)/2^RMS_SH), evaluated on each update.
- R11: A `start` edge clears `clip_count`, `sat_pct`, the window count, `lock_time`, `reacq_count`, `locked` and the error average.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Start or restart regulation; clears telemetry |
| amp_valid | input | 1 | Strobe for `amp_est` |
| amp_est | input | AW | Amplitude estimate (I/Q magnitude), unsigned |
| adc_clip | input | 1 | Clip flag for the current sample |
| setpoint | input | AW | Target amplitude |
| kp | input | GW | Proportional gain, FRAC fractional bits |
| ki | input | GW | Integral gain, FRAC fractional bits |
| drive_min | input | DW | Lower clamp of the drive |
| drive_max | input | DW | Upper clamp of the drive |
| ramp_step | input | DW | Maximum drive change per update |
| settle_band | input | AW | Error band used by the settle test |
| drive_level | output | DW | Drive word to the DAC/PWM stage |
| effort | output | DW+2 | Signed, unclamped control demand |
| sat_pct | output | 7 | Saturated share of the last window, in percent |
| clip_count | output | CW | Clipped samples since start |
| lock_time | output | TW | Clock edges from start to first lock |
| locked | output | 1 | Loop is settled |
| err_rms | output | AW+1 | RMS approximation of the loop error |
| reacq_count | output | CW | Number of re-settles after a loss |

## Verification
The bench builds the block with SETTLE_N = 8, SAT_WIN = 20 and RMS_SH = 3, and leaves AW, DW, GW and FRAC = 8 at their defaults. The short settle run lets the bench reach first lock, a loss on an error exactly equal to the band, and a re-settle within a few dozen updates. The 20-update window makes a saturation share of 90 percent fall out of a plain integral ramp into the upper clamp. The fast averaging lets the RMS figure converge on a constant error, and then decay to zero, within a few hundred updates.

// File: rtl/alc_pkg.sv
package alc_pkg;

   localparam int PCT_W = 7;

   typedef enum logic [1:0] {
      LS_IDLE = 2'd0,
      LS_ACQ  = 2'd1,
      LS_LOCK = 2'd2
   } lock_state_t;

endpackage

// File: rtl/alc_pi_core.sv
module alc_pi_core #(
   parameter int AW   = 12,
   parameter int DW   = 12,
   parameter int GW   = 16,
   parameter int FRAC = 8
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 restart,
   input  logic                 upd,
   input  logic signed [AW:0]   err,
   input  logic [GW-1:0]        kp,
   input  logic [GW-1:0]        ki,
   input  logic [DW-1:0]        dmin,
   input  logic [DW-1:0]        dmax,
   input  logic [DW-1:0]        step,
   output logic [DW-1:0]        drive,
   output logic signed [DW+1:0] effort,
   output logic                 sat_now
);

   localparam int WW = AW + GW + 8;
   localparam int EW = DW + 2;
   localparam logic signed [WW-1:0] E_HI = WW'((64'sd1 <<< (EW - 1)) - 64'sd1);
   localparam logic signed [WW-1:0] E_LO = -E_HI - WW'(1);

   logic signed [WW-1:0] integ_q;
   logic signed [WW-1:0] e_w, kp_w, ki_w, cand, dem, lo_w, hi_w;
   logic [DW-1:0]        target, gap;
   logic [DW-1:0]        drive_n;
   logic signed [EW-1:0] eff_n;

   always_comb begin
      e_w   = {{(WW-AW-1){err[AW]}}, err};
      kp_w  = {{(WW-GW){1'b0}}, kp};
      ki_w  = {{(WW-GW){1'b0}}, ki};
      cand  = integ_q + ki_w * e_w;
      dem   = (kp_w * e_w + cand) >>> FRAC;
      lo_w  = {{(WW-DW){1'b0}}, dmin};
      hi_w  = {{(WW-DW){1'b0}}, dmax};
      sat_now = (dem > hi_w) || (dem < lo_w);
      if (dem > hi_w)      target = dmax;
      else if (dem < lo_w) target = dmin;
      else                 target = dem[DW-1:0];
      if (target > drive) begin
         gap     = target - drive;
         drive_n = (gap > step) ? drive + step : target;
      end else begin
         gap     = drive - target;
         drive_n = (gap > step) ? drive - step : target;
      end
      if (dem > E_HI)      eff_n = E_HI[EW-1:0];
      else if (dem < E_LO) eff_n = E_LO[EW-1:0];
      else                 eff_n = dem[EW-1:0];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         integ_q <= '0;
         drive   <= '0;
         effort  <= '0;
      end else if (restart) begin
         integ_q <= '0;
         drive   <= '0;
         effort  <= '0;
      end else if (upd) begin
         if (!sat_now) integ_q <= cand;
         drive  <= drive_n;
         effort <= eff_n;
      end
   end

endmodule

// File: rtl/alc_settle_mon.sv
module alc_settle_mon
   import alc_pkg::*;
#(
   parameter int AW       = 12,
   parameter int CW       = 16,
   parameter int TW       = 24,
   parameter int SETTLE_N = 32
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               restart,
   input  logic               running,
   input  logic               upd,
   input  logic signed [AW:0] err,
   input  logic [AW-1:0]      band,
   output logic               locked,
   output logic [TW-1:0]      lock_time,
   output logic [CW-1:0]      reacq_count
);

   localparam int NW = (SETTLE_N > 1) ? $clog2(SETTLE_N) : 1;
   localparam logic [NW-1:0] LAST = NW'(SETTLE_N - 1);

   lock_state_t   st_q;
   logic [NW-1:0] run_q;
   logic [TW-1:0] timer_q, timer_inc;
   logic          seen_q;
   logic [AW:0]   mag;
   logic          in_band;

   always_comb begin
      mag       = err[AW] ? (~err + 1'b1) : err;
      in_band   = mag < {1'b0, band};
      timer_inc = (timer_q == '1) ? timer_q : timer_q + 1'b1;
   end

   assign locked = (st_q == LS_LOCK);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q        <= LS_IDLE;
         run_q       <= '0;
         timer_q     <= '0;
         seen_q      <= 1'b0;
         lock_time   <= '0;
         reacq_count <= '0;
      end else if (restart) begin
         st_q        <= LS_ACQ;
         run_q       <= '0;
         timer_q     <= '0;
         seen_q      <= 1'b0;
         lock_time   <= '0;
         reacq_count <= '0;
      end else begin
         if (running && !seen_q) timer_q <= timer_inc;
         if (upd) begin
            if (!in_band) begin
               run_q <= '0;
               st_q  <= LS_ACQ;
            end else if (st_q == LS_ACQ) begin
               if (run_q == LAST) begin
                  run_q <= '0;
                  st_q  <= LS_LOCK;
                  if (!seen_q) begin
                     seen_q    <= 1'b1;
                     lock_time <= timer_inc;
                  end else if (reacq_count != '1) begin
                     reacq_count <= reacq_count + 1'b1;
                  end
               end else begin
                  run_q <= run_q + 1'b1;
               end
            end
         end
      end
   end

endmodule

// File: rtl/alc_telemetry.sv
module alc_telemetry
   import alc_pkg::*;
#(
   parameter int AW      = 12,
   parameter int CW      = 16,
   parameter int SAT_WIN = 100,
   parameter int RMS_SH  = 4
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               restart,
   input  logic               upd,
   input  logic signed [AW:0] err,
   input  logic               sat_now,
   input  logic               clip,
   output logic [CW-1:0]      clip_count,
   output logic [PCT_W-1:0]   sat_pct,
   output logic [AW:0]        err_rms
);

   localparam int MW  = 2 * (AW + 1);
   localparam int RW  = AW + 1;
   localparam int SWW = $clog2(SAT_WIN + 1);

   logic [SWW-1:0]   win_q, satn_q, satn_nx;
   logic [PCT_W-1:0] pct_nx;
   logic [MW-1:0]    ms_q, sq;
   logic signed [MW:0] diff, ms_nx;
   logic [AW:0]      mag;

   function automatic logic [RW-1:0] isqrt(input logic [MW-1:0] v);
      logic [RW-1:0] r, t;
      r = '0;
      for (int i = RW - 1; i >= 0; i--) begin
         t = r | (RW'(1) << i);
         if ((MW'(t) * MW'(t)) <= v) r = t;
      end
      return r;
   endfunction

   assign satn_nx = satn_q + SWW'(sat_now);

   generate
      if (SAT_WIN == 100) begin : g_pct_direct
         assign pct_nx = PCT_W'(satn_nx);
      end else begin : g_pct_scaled
         assign pct_nx = PCT_W'((32'(satn_nx) * 32'd100) / 32'(SAT_WIN));
      end
   endgenerate

   always_comb begin
      mag   = err[AW] ? (~err + 1'b1) : err;
      sq    = MW'(mag) * MW'(mag);
      diff  = $signed({1'b0, sq}) - $signed({1'b0, ms_q});
      ms_nx = $signed({1'b0, ms_q}) + (diff >>> RMS_SH);
   end

   assign err_rms = isqrt(ms_q);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         clip_count <= '0;
         win_q      <= '0;
         satn_q     <= '0;
         sat_pct    <= '0;
         ms_q       <= '0;
      end else if (restart) begin
         clip_count <= '0;
         win_q      <= '0;
         satn_q     <= '0;
         sat_pct    <= '0;
         ms_q       <= '0;
      end else if (upd) begin
         if (clip && clip_count != '1) clip_count <= clip_count + 1'b1;
         ms_q <= ms_nx[MW-1:0];
         if (win_q == SWW'(SAT_WIN - 1)) begin
            sat_pct <= pct_nx;
            win_q   <= '0;
            satn_q  <= '0;
         end else begin
            win_q  <= win_q + 1'b1;
            satn_q <= satn_nx;
         end
      end
   end

endmodule

// File: rtl/amp_loop_ctrl.sv
module amp_loop_ctrl
   import alc_pkg::*;
#(
   parameter int AW       = 12,
   parameter int DW       = 12,
   parameter int GW       = 16,
   parameter int FRAC     = 8,
   parameter int CW       = 16,
   parameter int TW       = 24,
   parameter int SETTLE_N = 32,
   parameter int SAT_WIN  = 100,
   parameter int RMS_SH   = 4
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 start,
   input  logic                 amp_valid,
   input  logic [AW-1:0]        amp_est,
   input  logic                 adc_clip,
   input  logic [AW-1:0]        setpoint,
   input  logic [GW-1:0]        kp,
   input  logic [GW-1:0]        ki,
   input  logic [DW-1:0]        drive_min,
   input  logic [DW-1:0]        drive_max,
   input  logic [DW-1:0]        ramp_step,
   input  logic [AW-1:0]        settle_band,
   output logic [DW-1:0]        drive_level,
   output logic signed [DW+1:0] effort,
   output logic [6:0]           sat_pct,
   output logic [CW-1:0]        clip_count,
   output logic [TW-1:0]        lock_time,
   output logic                 locked,
   output logic [AW:0]          err_rms,
   output logic [CW-1:0]        reacq_count
);

   generate
      if (AW < 4 || DW < 4)            begin : g_bad_width $error("AW and DW must be at least 4"); end
      if (FRAC < 0 || FRAC >= GW)      begin : g_bad_frac  $error("FRAC must lie in [0, GW)"); end
      if (SETTLE_N < 2)                begin : g_bad_settle $error("SETTLE_N must be at least 2"); end
      if (SAT_WIN < 1 || SAT_WIN > 65535) begin : g_bad_win $error("SAT_WIN out of range"); end
      if (RMS_SH < 1 || RMS_SH > 8)    begin : g_bad_sh    $error("RMS_SH must lie in [1, 8]"); end
      if (PCT_W != 7)                  begin : g_bad_pct   $error("percentage width mismatch"); end
   endgenerate

   logic               running;
   logic               upd;
   logic signed [AW:0] err;
   logic               sat_now;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     running <= 1'b0;
      else if (start) running <= 1'b1;
   end

   assign upd = amp_valid && running && !start;
   assign err = $signed({1'b0, setpoint}) - $signed({1'b0, amp_est});

   alc_pi_core #(.AW(AW), .DW(DW), .GW(GW), .FRAC(FRAC)) u_pi (
      .clk(clk), .rst_n(rst_n), .restart(start), .upd(upd), .err(err),
      .kp(kp), .ki(ki), .dmin(drive_min), .dmax(drive_max), .step(ramp_step),
      .drive(drive_level), .effort(effort), .sat_now(sat_now)
   );

   alc_settle_mon #(.AW(AW), .CW(CW), .TW(TW), .SETTLE_N(SETTLE_N)) u_settle (
      .clk(clk), .rst_n(rst_n), .restart(start), .running(running), .upd(upd),
      .err(err), .band(settle_band), .locked(locked), .lock_time(lock_time),
      .reacq_count(reacq_count)
   );

   alc_telemetry #(.AW(AW), .CW(CW), .SAT_WIN(SAT_WIN), .RMS_SH(RMS_SH)) u_tel (
      .clk(clk), .rst_n(rst_n), .restart(start), .upd(upd), .err(err),
      .sat_now(sat_now), .clip(adc_clip), .clip_count(clip_count),
      .sat_pct(sat_pct), .err_rms(err_rms)
   );

endmodule

// File: rtl/alc_loop_chk.sv
module alc_loop_chk #(
   parameter int AW = 12,
   parameter int DW = 12,
   parameter int CW = 16
) (
   input logic               clk,
   input logic               rst_n,
   input logic               running,
   input logic               upd,
   input logic signed [AW:0] err,
   input logic [AW-1:0]      settle_band,
   input logic [DW-1:0]      drive_level,
   input logic [DW-1:0]      drive_max,
   input logic [DW-1:0]      ramp_step,
   input logic [6:0]         sat_pct,
   input logic [CW-1:0]      clip_count,
   input logic               locked,
   input logic [CW-1:0]      reacq_count
);

   logic [AW:0] mag;
   logic        inb_upd;
   assign mag     = err[AW] ? (~err + 1'b1) : err;
   assign inb_upd = upd && (mag < {1'b0, settle_band});

   a_r1_idle_drive: assert property (@(posedge clk) disable iff (!rst_n)
      !running |-> (drive_level == '0));

   a_r3_rise_within_max: assert property (@(posedge clk) disable iff (!rst_n)
      (drive_level > $past(drive_level)) |-> (drive_level <= $past(drive_max)));

   a_r4_rise_within_step: assert property (@(posedge clk) disable iff (!rst_n)
      (drive_level > $past(drive_level)) |-> ((drive_level - $past(drive_level)) <= $past(ramp_step)));

   a_r6_clip_single_step: assert property (@(posedge clk) disable iff (!rst_n)
      (clip_count != $past(clip_count)) |-> ((clip_count == $past(clip_count) + 1'b1) || (clip_count == '0)));

   a_r7_pct_bounded: assert property (@(posedge clk) disable iff (!rst_n)
      sat_pct <= 7'd100);

   a_r8_lock_after_inband: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(locked) |-> $past(inb_upd));

   a_r9_reacq_with_relock: assert property (@(posedge clk) disable iff (!rst_n)
      ((reacq_count != $past(reacq_count)) && (reacq_count != '0)) |-> $rose(locked));

endmodule

bind amp_loop_ctrl alc_loop_chk #(.AW(AW), .DW(DW), .CW(CW)) u_chk (
   .clk(clk), .rst_n(rst_n), .running(running), .upd(upd), .err(err),
   .settle_band(settle_band), .drive_level(drive_level), .drive_max(drive_max),
   .ramp_step(ramp_step), .sat_pct(sat_pct), .clip_count(clip_count),
   .locked(locked), .reacq_count(reacq_count)
);

// File: tb/amp_loop_ctrl_bench.sv
module amp_loop_ctrl_bench;

   localparam int CLK_PERIOD = 10;
   localparam int AW = 12, DW = 12, GW = 16, CW = 16, TW = 24;

   logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, amp_valid = 1'b0, adc_clip = 1'b0;
   logic [AW-1:0] amp_est = '0, setpoint = '0, settle_band = '0;
   logic [GW-1:0] kp = '0, ki = '0;
   logic [DW-1:0] drive_min = '0, drive_max = '0, ramp_step = '0;
   logic [DW-1:0] drive_level;
   logic signed [DW+1:0] effort;
   logic [6:0] sat_pct;
   logic [CW-1:0] clip_count, reacq_count;
   logic [TW-1:0] lock_time;
   logic locked;
   logic [AW:0] err_rms;

   int checks = 0, errors = 0;
   bit done = 1'b0;

   always #(CLK_PERIOD / 2) clk = ~clk;

   amp_loop_ctrl #(.SETTLE_N(8), .SAT_WIN(20), .RMS_SH(3)) u_amp_loop_ctrl (
      .clk(clk), .rst_n(rst_n), .start(start), .amp_valid(amp_valid), .amp_est(amp_est),
      .adc_clip(adc_clip), .setpoint(setpoint), .kp(kp), .ki(ki), .drive_min(drive_min),
      .drive_max(drive_max), .ramp_step(ramp_step), .settle_band(settle_band),
      .drive_level(drive_level), .effort(effort), .sat_pct(sat_pct), .clip_count(clip_count),
      .lock_time(lock_time), .locked(locked), .err_rms(err_rms), .reacq_count(reacq_count)
   );

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic do_start();
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
   endtask

   task automatic run_upd(input int n, input int amp, input bit clip);
      amp_est   = AW'(amp);
      adc_clip  = clip;
      amp_valid = 1'b1;
      repeat (n) @(negedge clk);
      amp_valid = 1'b0;
      adc_clip  = 1'b0;
   endtask

   task automatic t_reset();
      chk(drive_level == 0, "R1 drive", int'(drive_level), 0);
      chk(effort == 0 && sat_pct == 0 && lock_time == 0, "R1 telemetry", int'(sat_pct), 0);
      chk(!locked && clip_count == 0 && reacq_count == 0 && err_rms == 0, "R1 flags", int'(clip_count), 0);
   endtask

   task automatic t_ignore_before_start();
      setpoint = 12'd1000; kp = 16'd1024; drive_max = 12'd300; ramp_step = 12'd10;
      run_upd(3, 0, 1'b1);
      chk(drive_level == 0, "R1 strobe ignored drive", int'(drive_level), 0);
      chk(clip_count == 0 && effort == 0, "R1 strobe ignored telemetry", int'(clip_count), 0);
   endtask

   task automatic t_ramp_clamp();
      setpoint = 12'd1000; kp = 16'd1024; ki = 0;
      drive_min = 12'd20; drive_max = 12'd300; ramp_step = 12'd10;
      do_start();
      run_upd(5, 0, 1'b0);
      chk(drive_level == 50, "R4 bounded ramp", int'(drive_level), 50);
      chk(effort == 4000, "R2 proportional demand", int'(effort), 4000);
      run_upd(30, 0, 1'b0);
      chk(drive_level == 300, "R3 upper clamp", int'(drive_level), 300);
      kp = 16'd256;
      run_upd(40, 1100, 1'b0);
      chk(drive_level == 20, "R3 lower clamp", int'(drive_level), 20);
      chk(effort == -100, "R2 negative demand", int'(effort), -100);
   endtask

   task automatic t_sat_windup();
      setpoint = 12'd1000; kp = 0; ki = 16'd256;
      drive_min = 0; drive_max = 12'd200; ramp_step = 12'd4095;
      do_start();
      run_upd(19, 900, 1'b0);
      chk(sat_pct == 0, "R7 holds before window end", int'(sat_pct), 0);
      run_upd(1, 900, 1'b0);
      chk(sat_pct == 90, "R7 window percentage", int'(sat_pct), 90);
      chk(drive_level == 200, "R3 integral into clamp", int'(drive_level), 200);
      run_upd(1, 1050, 1'b0);
      chk(drive_level == 150, "R5 anti-windup release", int'(drive_level), 150);
      chk(effort == 150, "R2 integral demand", int'(effort), 150);
   endtask

   task automatic t_clip();
      kp = 0; ki = 0; drive_min = 0;
      do_start();
      run_upd(3, 1000, 1'b1);
      run_upd(2, 1000, 1'b0);
      chk(clip_count == 3, "R6 clip count", int'(clip_count), 3);
      do_start();
      chk(clip_count == 0 && sat_pct == 0, "R11 start clears", int'(clip_count), 0);
   endtask

   task automatic t_settle();
      kp = 0; ki = 0; setpoint = 12'd1000; settle_band = 12'd5;
      do_start();
      run_upd(7, 1003, 1'b0);
      chk(!locked, "R8 not yet settled", int'(locked), 0);
      run_upd(1, 1003, 1'b0);
      chk(locked, "R8 settled", int'(locked), 1);
      chk(lock_time == 8, "R8 lock time", int'(lock_time), 8);
      run_upd(1, 1005, 1'b0);
      chk(!locked, "R8 loss at band edge", int'(locked), 0);
      run_upd(8, 1000, 1'b0);
      chk(locked && reacq_count == 1, "R9 reacquire count", int'(reacq_count), 1);
      chk(lock_time == 8, "R8 lock time kept", int'(lock_time), 8);
      do_start();
      chk(reacq_count == 0 && lock_time == 0 && !locked, "R11 settle cleared", int'(reacq_count), 0);
   endtask

   task automatic t_rms();
      kp = 0; ki = 0; setpoint = 12'd1000;
      do_start();
      run_upd(100, 960, 1'b0);
      chk(err_rms == 39 || err_rms == 40, "R10 rms converges", int'(err_rms), 40);
      run_upd(200, 1000, 1'b0);
      chk(err_rms == 0, "R10 rms decays", int'(err_rms), 0);
      do_start();
      chk(err_rms == 0, "R11 rms cleared", int'(err_rms), 0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_ignore_before_start();
      t_ramp_clamp();
      t_sat_windup();
      t_clip();
      t_settle();
      t_rms();
      if (!done) begin
         done = 1'b1;
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      #(CLK_PERIOD * 200000);
      if (!done) begin
         done = 1'b1;
         checks++;
         errors++;
         $display("FAIL watchdog actual %0d expected %0d", 1, 0);
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

endmodule